// File: doc/BRIEF.md
# Parity-Routed Dual-Path Stream Processor

This block takes a stream of signed 32-bit words through a valid/ready input. It sorts each word onto one of two independent paths by the word's lowest bit. Each path has its own small channel FIFO and its own worker stage, and each worker adds a fixed increment. Odd words come out of the odd stream with 1 added. Even words come out of the even stream with 2 added. Each result is presented on that path's own valid/ready output.

No start or done control exists. The splitter, both channels and both workers act as soon as data is present and stall only on back-pressure. A consumer that stalls one output stream fills only that path. Words of the other parity keep flowing. Words keep their arrival order within a stream, but no ordering holds between the two streams.

Top module: `parity_stream_router`

## Requirements
- R1: An input word with bit 0 equal to 0 leaves on the even output stream, and a word with bit 0 equal to 1 leaves on the odd output stream. Bit 0 of the two's-complement value decides this for negative words too.
- R2: The odd stream carries the accepted word plus 1, wrapping modulo 2^32 (0x7FFFFFFF gives 0x80000000, and 0xFFFFFFFF gives 0x00000000).
- R3: The even stream carries the accepted word plus 2, wrapping modulo 2^32 (0xFFFFFFFE gives 0x00000000).
- R4: Each path holds BURST_N/2 words in its channel plus one word in its worker output register. With BURST_N=8 and that output stalled, exactly 5 words of one parity are accepted before `in_ready` drops for that parity.
- R5: `in_ready` depends only on whether the channel for the presented word's parity has space. A full odd path does not block an even word, and the reverse also holds.
- R6: Within each output stream, words leave in the order they were accepted at the input.
- R7: While an output's valid is high and its ready is low, that output's valid and data hold unchanged.
- R8: Reset is synchronous and active low. After a cycle with `rst_n` low, both output valids are low, both channels are empty, and `in_ready` is high. Words that were held before reset never appear.
- R9: The block has no start control. A word accepted at clock edge k into an idle path is not yet presented after edge k. It is presented with valid high after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word taken when high together with in_valid |
| in_data | input | DATA_W | Signed input word |
| odd_valid | output | 1 | Odd-stream word presented |
| odd_ready | input | 1 | Odd-stream consumer accepts |
| odd_data | output | DATA_W | Odd word plus ODD_INC |
| even_valid | output | 1 | Even-stream word presented |
| even_ready | input | 1 | Even-stream consumer accepts |
| even_data | output | DATA_W | Even word plus EVEN_INC |

## Verification
The main function is driven by a mixed table. It holds small positive words of both parities, negative words whose parity comes only from the two's-complement bit 0, and values at the wrap points of each increment. This separates a routing error from an offset error and from a carry or wrap error. Directed runs stall one output to measure the per-path capacity. In the same runs an opposite-parity word is offered to show it bypasses the stalled path, and the stalled output is watched to confirm it holds steady. A reset issued while both paths hold data must leave nothing behind.

// File: rtl/psr_pkg.sv
// Package: shared types for the parity-routed stream processor.
// Assumes: only bit 0 of a word selects its path.
package psr_pkg;

    // Path index; the numeric value equals the word's bit 0.
    typedef enum logic {
        PATH_EVEN = 1'b0,
        PATH_ODD  = 1'b1
    } path_e;

    localparam int NUM_PATHS = 2;

endpackage

// File: rtl/psr_chan_fifo.sv
// Module: psr_chan_fifo
// What: single-clock channel FIFO with DEPTH entries and a same-cycle
//       read and write. rd_data shows the head entry whenever empty is low.
// Assumes: the producer offers a write only while full is low, and the
//          consumer pops only while empty is low. Reset is synchronous and
//          active low. Stored data is not cleared by reset.
module psr_chan_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [CW-1:0] count;
    logic          do_wr;
    logic          do_rd;

    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign rd_data = mem[rptr];

    // Store the incoming word at the write pointer.
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wptr] <= wr_data;
        end
    end

    // Advance the write pointer with wrap; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
        end else if (do_wr) begin
            wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
        end
    end

    // Advance the read pointer with wrap; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr <= '0;
        end else if (do_rd) begin
            rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
        end
    end

    // Track the fill level from the push and pop pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr_en) else $error("write offered to full channel"); // R5
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)) else $error("channel level past depth"); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !rd_en) else $error("pop from empty channel"); // R6

endmodule

// File: rtl/psr_splitter.sv
// Module: psr_splitter
// What: steers each offered word to the channel that bit 0 selects. It
//       asserts in_ready only when that channel has room, so a full
//       channel stalls words of its own parity and no others.
// Assumes: ch_full comes from registers, which keeps in_ready free of
//          combinational loops.
module psr_splitter
    import psr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                 in_valid,
    input  logic [W-1:0]         in_data,
    output logic                 in_ready,
    input  logic [NUM_PATHS-1:0] ch_full,
    output logic [NUM_PATHS-1:0] ch_push
);

    path_e sel;

    // Pick the path from the word's lowest bit.
    always_comb begin
        sel = path_e'(in_data[0]);
    end

    // Accept only when the chosen channel has space.
    always_comb begin
        in_ready = !ch_full[sel];
    end

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_push
        // Push into this channel on a handshake for its parity.
        always_comb begin
            ch_push[p] = in_valid && in_ready && (sel == path_e'(p));
        end
    end

endmodule

// File: rtl/psr_worker.sv
// Module: psr_worker
// What: pulls the head word from its channel, adds INC, and holds the
//       sum in an output register with valid/ready. It loads a new word
//       whenever the register is empty or is being drained.
// Assumes: ch_valid is the channel's not-empty flag. Reset is
//          synchronous and active low.
module psr_worker #(
    parameter int W   = 32,
    parameter int INC = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ch_valid,
    input  logic [W-1:0] ch_data,
    output logic         ch_pop,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    localparam logic [W-1:0] INC_W = W'(INC);

    logic load;

    // Take a word when data waits and the register is free or draining.
    always_comb begin
        load   = ch_valid && (!out_valid || out_ready);
        ch_pop = load;
    end

    // Output valid: set on load, clear on drain with nothing to follow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Output data: the channel word plus the fixed increment, wrapping.
    always_ff @(posedge clk) begin
        if (load) begin
            out_data <= ch_data + INC_W;
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data))
        else $error("output changed while stalled"); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> !out_valid) else $error("valid set after reset"); // R8

endmodule

// File: rtl/parity_stream_router.sv
// Module: parity_stream_router
// What: top of the dual-path stream processor. The splitter sorts words
//       by parity into two channel FIFOs of BURST_N/2 entries. Each
//       channel feeds a worker that adds its increment and drives its own
//       output stream. All stages run freely with no start control.
// Assumes: BURST_N >= 2. Reset is synchronous and active low.
module parity_stream_router
    import psr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int BURST_N  = 8,
    parameter int ODD_INC  = 1,
    parameter int EVEN_INC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              odd_valid,
    input  logic              odd_ready,
    output logic [DATA_W-1:0] odd_data,
    output logic              even_valid,
    input  logic              even_ready,
    output logic [DATA_W-1:0] even_data
);

    localparam int CH_DEPTH = BURST_N / 2;

    logic [NUM_PATHS-1:0] ch_full;
    logic [NUM_PATHS-1:0] ch_empty;
    logic [NUM_PATHS-1:0] ch_push;
    logic [NUM_PATHS-1:0] ch_pop;
    logic [DATA_W-1:0]    ch_head [NUM_PATHS];
    logic [NUM_PATHS-1:0] o_valid;
    logic [NUM_PATHS-1:0] o_ready;
    logic [DATA_W-1:0]    o_data  [NUM_PATHS];

    psr_splitter #(
        .W (DATA_W)
    ) u_split (
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .ch_full  (ch_full),
        .ch_push  (ch_push)
    );

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        localparam int P_INC = (p == int'(PATH_ODD)) ? ODD_INC : EVEN_INC;

        psr_chan_fifo #(
            .W     (DATA_W),
            .DEPTH (CH_DEPTH)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (ch_push[p]),
            .wr_data (in_data),
            .rd_en   (ch_pop[p]),
            .rd_data (ch_head[p]),
            .empty   (ch_empty[p]),
            .full    (ch_full[p])
        );

        psr_worker #(
            .W   (DATA_W),
            .INC (P_INC)
        ) u_work (
            .clk       (clk),
            .rst_n     (rst_n),
            .ch_valid  (!ch_empty[p]),
            .ch_data   (ch_head[p]),
            .ch_pop    (ch_pop[p]),
            .out_valid (o_valid[p]),
            .out_ready (o_ready[p]),
            .out_data  (o_data[p])
        );
    end

    // Map the per-path arrays onto the named output streams.
    always_comb begin
        odd_valid        = o_valid[PATH_ODD];
        odd_data         = o_data[PATH_ODD];
        even_valid       = o_valid[PATH_EVEN];
        even_data        = o_data[PATH_EVEN];
        o_ready[PATH_ODD]  = odd_ready;
        o_ready[PATH_EVEN] = even_ready;
    end

    AST_ROUTE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_data[0] |=> !ch_empty[PATH_EVEN])
        else $error("even word missing from even channel"); // R1
    AST_ROUTE_ODD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_data[0] |=> !ch_empty[PATH_ODD])
        else $error("odd word missing from odd channel"); // R1

endmodule

// File: tb/parity_stream_router_tb.sv
// Bench for parity_stream_router: a table pass, then directed tests.
module parity_stream_router_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 32;
    localparam int NV         = 10;

    localparam logic [W-1:0] TV_IN [NV] = '{
        32'h0000_0004, 32'h0000_0007, 32'hFFFF_FFFD, 32'hFFFF_FFFC,
        32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h0000_0000,
        32'h1234_5679, 32'h7FFF_FFFE };
    localparam logic [W-1:0] TV_EXP [NV] = '{
        32'h0000_0006, 32'h0000_0008, 32'hFFFF_FFFE, 32'hFFFF_FFFE,
        32'h8000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0002,
        32'h1234_567A, 32'h8000_0000 };
    localparam bit TV_ODD [NV] = '{0, 1, 1, 0, 1, 1, 0, 0, 1, 0};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [W-1:0] in_data = '0;
    logic         odd_valid, even_valid;
    logic         odd_ready = 1'b1, even_ready = 1'b1;
    logic [W-1:0] odd_data, even_data;

    int  errors = 0;
    int  checks = 0;
    bit  done   = 1'b0;
    bit  mon_en = 1'b0;

    logic [W-1:0] exp_odd  [64];
    logic [W-1:0] exp_even [64];
    int odd_wr = 0, odd_rd = 0, even_wr = 0, even_rd = 0;

    parity_stream_router u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .odd_valid  (odd_valid),
        .odd_ready  (odd_ready),
        .odd_data   (odd_data),
        .even_valid (even_valid),
        .even_ready (even_ready),
        .even_data  (even_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Offer one word for one cycle; record the expected result if taken.
    task automatic try_push(input logic [W-1:0] w, input logic [W-1:0] e,
                            input bit is_odd, output bit ok);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        #1;
        ok = in_ready;
        if (ok) begin
            if (is_odd) begin exp_odd[odd_wr % 64] = e; odd_wr++; end
            else        begin exp_even[even_wr % 64] = e; even_wr++; end
            @(posedge clk);
            #1;
        end
        in_valid = 1'b0;
    endtask

    task automatic push(input logic [W-1:0] w, input logic [W-1:0] e,
                        input bit is_odd);
        bit ok;
        ok = 1'b0;
        for (int t = 0; t < 50 && !ok; t++) try_push(w, e, is_odd, ok);
        check(ok, "R5", "word never accepted", {31'd0, ok}, 1);
    endtask

    task automatic wait_drain();
        for (int t = 0; t < 100; t++) begin
            if (odd_rd == odd_wr && even_rd == even_wr) break;
            @(negedge clk);
        end
        check(odd_rd == odd_wr && even_rd == even_wr, "R6",
              "streams not drained", W'(odd_rd + even_rd), W'(odd_wr + even_wr));
    endtask

    // Scoreboard: each handshake must match the next expected word.
    always @(negedge clk) begin
        if (mon_en && rst_n && odd_valid && odd_ready) begin
            check(odd_rd < odd_wr && odd_data == exp_odd[odd_rd % 64], "R1 R2 R6",
                  "odd stream word", odd_data, exp_odd[odd_rd % 64]);
            odd_rd++;
        end
        if (mon_en && rst_n && even_valid && even_ready) begin
            check(even_rd < even_wr && even_data == exp_even[even_rd % 64], "R1 R3 R6",
                  "even stream word", even_data, exp_even[even_rd % 64]);
            even_rd++;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit ok;
        int taken;
        logic [W-1:0] held;

        // Reset state (R8)
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(!odd_valid && !even_valid, "R8", "valids after reset",
              {30'd0, odd_valid, even_valid}, 0);
        check(in_ready == 1'b1, "R8", "in_ready after reset", {31'd0, in_ready}, 1);
        mon_en = 1'b1;

        // Table pass with both outputs ready (R1 R2 R3 R6)
        for (int i = 0; i < NV; i++) push(TV_IN[i], TV_EXP[i], TV_ODD[i]);
        wait_drain();

        // Latency from an idle path (R9)
        try_push(32'd5, 32'd6, 1'b1, ok);
        check(ok, "R9", "idle word accepted", {31'd0, ok}, 1);
        @(negedge clk);
        check(!odd_valid, "R9", "valid after accept edge", {31'd0, odd_valid}, 0);
        @(negedge clk);
        check(odd_valid && odd_data == 32'd6, "R9", "output one edge later", odd_data, 6);
        wait_drain();

        // Capacity with the odd output stalled (R4)
        @(posedge clk); #1 odd_ready = 1'b0;
        taken = 0;
        for (int i = 0; i < 8; i++) begin
            try_push(W'(101 + 2 * i), W'(102 + 2 * i), 1'b1, ok);
            if (ok) taken++;
        end
        check(taken == 5, "R4", "odd words taken while stalled", W'(taken), 5);

        // Even word bypasses the full odd path (R5)
        try_push(32'd20, 32'd22, 1'b0, ok);
        check(ok, "R5", "even word with odd path full", {31'd0, ok}, 1);

        // Stalled output holds (R7)
        @(negedge clk);
        held = odd_data;
        check(odd_valid && held == 32'd102, "R7", "stalled head word", held, 102);
        repeat (3) @(negedge clk);
        check(odd_valid && odd_data == held, "R7", "stalled word held", odd_data, held);

        @(posedge clk); #1 odd_ready = 1'b1;
        wait_drain();

        // Reset while both paths hold data (R8)
        @(posedge clk); #1;
        mon_en = 1'b0; odd_ready = 1'b0; even_ready = 1'b0;
        push(32'd41, 32'd42, 1'b1);
        push(32'd43, 32'd44, 1'b1);
        push(32'd50, 32'd52, 1'b0);
        push(32'd60, 32'd62, 1'b0);
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        in_data = 32'd1;
        @(negedge clk);
        check(!odd_valid && !even_valid, "R8", "valids cleared by reset",
              {30'd0, odd_valid, even_valid}, 0);
        check(in_ready == 1'b1, "R8", "in_ready after mid-run reset", {31'd0, in_ready}, 1);
        @(posedge clk); #1 odd_ready = 1'b1; even_ready = 1'b1;
        ok = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (odd_valid || even_valid) ok = 1'b1;
        end
        check(!ok, "R8", "no word survives reset", {31'd0, ok}, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule